// File: doc/BRIEF.md
# Configurable Pad Cell Bank

The block is a bank of universal pad cells. Each one sits between a logic-block output and a device pad. Every cell holds its own small configuration word, and that word sets four things:
- whether the cell works as an input, an output or a three-state bidirectional pin;
- whether the driver pushes both levels (totem-pole) or only pulls low (open-drain);
- which signal enables the driver in bidirectional mode;
- a stored slew-rate bit.

The pad itself is modelled as three signals: the value driven out, a drive enable, and the value read back. The value read back from each pad always goes to the routing network, whatever mode the cell is in.

Configuration is written one cell at a time with a write strobe and a cell index. Reset returns every cell to the erased configuration, which is the all-zero word. The data path from the logic-block signals and the enable pins to the pad is combinational. The configuration registers are the only storage in the block.

Top module: `ioc_bank`

## Requirements
- R1: After reset every cell holds the all-zero word: input-only, totem-pole, always-on source and fast slew. No pad is driven while the cell is in that state.
- R2: When `cfg_we` is high at a rising clock edge, `cfg_word` is stored into cell `cfg_idx` and every other cell keeps its word. The new word takes effect from that edge. The fields are: bits [1:0] mode, bit [2] open-drain, bits [4:3] enable source, bit [5] slow slew.
- R3: Mode values 0 and 3 make the cell input-only. Its `pad_oe` stays 0 whatever the two global enables and its product-term enable do.
- R4: In mode 1 (output-only) the driver is enabled at all times and the enable-source field has no effect.
- R5: In mode 2 (bidirectional) the enable-source field picks the driver enable: 0 means always on, 1 means `goe0`, 2 means `goe1`, and 3 means the cell's own `cell_pt_oe` bit.
- R6: A totem-pole cell (bit 2 = 0) drives `pad_out` equal to `cell_dout`, and its `pad_oe` equals the enable chosen by R3 to R5.
- R7: An open-drain cell (bit 2 = 1) always has `pad_out` at 0. Its `pad_oe` is high only when the chosen enable is high and `cell_dout` is 0, so a data 1 releases the pad.
- R8: `grp_in` equals `pad_in` for every cell in every mode.
- R9: `pad_slow` shows each cell's stored slew bit.
- R10: While `cfg_we` is low, changes on `cfg_idx` and `cfg_word` leave every stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low reset; returns all cells to the erased word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | $clog2(NCELL) | Index of the cell to write |
| cfg_word | input | 6 | Configuration word to store |
| goe0 | input | 1 | Global output enable 0 |
| goe1 | input | 1 | Global output enable 1 |
| cell_dout | input | NCELL | Data from the logic block, one bit per cell |
| cell_pt_oe | input | NCELL | Product-term enable from the logic block, one bit per cell |
| pad_in | input | NCELL | Level seen at each pad |
| pad_out | output | NCELL | Value driven toward each pad |
| pad_oe | output | NCELL | Driver enable for each pad |
| pad_slow | output | NCELL | Stored slew-rate bit for each cell |
| grp_in | output | NCELL | Pad level returned to the routing network |

## Verification
The hardest case to reach is a bank in which every mode, drive style and enable source is live at the same moment. Only then does a wrong field decode, or a crossed wire between cells, show up as a wrong bit in a neighbour. The stimulus therefore programs eight cells with eight different words. It then sweeps both global enables, the product-term enables and the data through inverse and alternating patterns, so each cell's enable changes independently of the others. A write strobe held low while the index and word toggle, and a reset in the middle of the run, show that the stored words change only on a real write and return to the erased state on reset.

// File: rtl/ioc_pkg.sv
package ioc_pkg;

  typedef enum logic [1:0] {
    MODE_IN     = 2'd0,
    MODE_OUT    = 2'd1,
    MODE_BIDIR  = 2'd2,
    MODE_IN_ALT = 2'd3
  } ioc_mode_e;

  typedef enum logic [1:0] {
    SRC_ON  = 2'd0,
    SRC_G0  = 2'd1,
    SRC_G1  = 2'd2,
    SRC_PT  = 2'd3
  } ioc_src_e;

  // field layout, msb first: slew, source, open-drain, mode
  typedef struct packed {
    logic      slow;
    ioc_src_e  src;
    logic      odrain;
    ioc_mode_e mode;
  } ioc_cfg_t;

  localparam int IOC_CFG_W = $bits(ioc_cfg_t);

  // driver enable chosen by the mode and the enable-source field
  function automatic logic f_enable(ioc_cfg_t c, logic g0, logic g1, logic pt);
    logic sel;
    unique case (c.src)
      SRC_ON:  sel = 1'b1;
      SRC_G0:  sel = g0;
      SRC_G1:  sel = g1;
      default: sel = pt;
    endcase
    unique case (c.mode)
      MODE_OUT:   return 1'b1;
      MODE_BIDIR: return sel;
      default:    return 1'b0;
    endcase
  endfunction

  // output level toward the pad for the selected drive style
  function automatic logic f_level(logic odrain, logic dout);
    return odrain ? 1'b0 : dout;
  endfunction

  // pad enable for the selected drive style
  function automatic logic f_oe(logic odrain, logic en, logic dout);
    return odrain ? (en & ~dout) : en;
  endfunction

endpackage

// File: rtl/ioc_cfg_store.sv
module ioc_cfg_store
  import ioc_pkg::*;
#(
  parameter int NCELL = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(NCELL)-1:0] idx,
  input  logic [IOC_CFG_W-1:0]     word,
  output logic [NCELL*IOC_CFG_W-1:0] cfg_flat
);
  localparam int IW = $clog2(NCELL);

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic [IOC_CFG_W-1:0] r_cfg;
    logic                 hit;
    assign hit = we && (idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   r_cfg <= '0;
      else if (hit) r_cfg <= word;
    end
    assign cfg_flat[i*IOC_CFG_W +: IOC_CFG_W] = r_cfg;
  end
endmodule

// File: rtl/ioc_oe_mux.sv
module ioc_oe_mux
  import ioc_pkg::*;
(
  input  ioc_cfg_t cfg,
  input  logic     goe0,
  input  logic     goe1,
  input  logic     pt_oe,
  output logic     drv_en
);
  always_comb drv_en = f_enable(cfg, goe0, goe1, pt_oe);
endmodule

// File: rtl/ioc_driver.sv
module ioc_driver
  import ioc_pkg::*;
(
  input  logic odrain,
  input  logic drv_en,
  input  logic dout,
  output logic pad_out,
  output logic pad_oe
);
  always_comb begin
    pad_out = f_level(odrain, dout);
    pad_oe  = f_oe(odrain, drv_en, dout);
  end
endmodule

// File: rtl/ioc_bank.sv
module ioc_bank
  import ioc_pkg::*;
#(
  parameter int NCELL = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [$clog2(NCELL)-1:0] cfg_idx,
  input  logic [IOC_CFG_W-1:0]     cfg_word,
  input  logic                     goe0,
  input  logic                     goe1,
  input  logic [NCELL-1:0]         cell_dout,
  input  logic [NCELL-1:0]         cell_pt_oe,
  input  logic [NCELL-1:0]         pad_in,
  output logic [NCELL-1:0]         pad_out,
  output logic [NCELL-1:0]         pad_oe,
  output logic [NCELL-1:0]         pad_slow,
  output logic [NCELL-1:0]         grp_in
);
  // named internal events, observed by the bound checker
  logic [NCELL*IOC_CFG_W-1:0] cfg_flat;
  logic [NCELL-1:0]           drv_en;
  logic [NCELL-1:0]           is_input_only;
  logic [NCELL-1:0]           is_od;

  ioc_cfg_store #(.NCELL(NCELL)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (cfg_we),
    .idx      (cfg_idx),
    .word     (cfg_word),
    .cfg_flat (cfg_flat)
  );

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    ioc_cfg_t c;
    assign c = ioc_cfg_t'(cfg_flat[i*IOC_CFG_W +: IOC_CFG_W]);
    assign is_input_only[i] = (c.mode == MODE_IN) || (c.mode == MODE_IN_ALT);
    assign is_od[i]         = c.odrain;
    assign pad_slow[i]      = c.slow;

    ioc_oe_mux u_mux (
      .cfg    (c),
      .goe0   (goe0),
      .goe1   (goe1),
      .pt_oe  (cell_pt_oe[i]),
      .drv_en (drv_en[i])
    );

    ioc_driver u_drv (
      .odrain  (c.odrain),
      .drv_en  (drv_en[i]),
      .dout    (cell_dout[i]),
      .pad_out (pad_out[i]),
      .pad_oe  (pad_oe[i])
    );
  end

  // pad level always returns to the routing network
  assign grp_in = pad_in;
endmodule

// File: rtl/ioc_bank_chk.sv
module ioc_bank_chk
  import ioc_pkg::*;
#(
  parameter int NCELL = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_we,
  input logic [$clog2(NCELL)-1:0]   cfg_idx,
  input logic [IOC_CFG_W-1:0]       cfg_word,
  input logic [NCELL*IOC_CFG_W-1:0] cfg_flat,
  input logic [NCELL-1:0]           drv_en,
  input logic [NCELL-1:0]           is_input_only,
  input logic [NCELL-1:0]           is_od,
  input logic [NCELL-1:0]           pad_in,
  input logic [NCELL-1:0]           pad_out,
  input logic [NCELL-1:0]           pad_oe,
  input logic [NCELL-1:0]           grp_in
);
  p_erased_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (cfg_flat == '0 && pad_oe == '0));

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_flat[$past(cfg_idx)*IOC_CFG_W +: IOC_CFG_W] == $past(cfg_word)));

  p_input_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_input_only & pad_oe) == '0);

  p_totem_follows_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((~is_od) & (drv_en ^ pad_oe)) == '0);

  p_od_never_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((is_od & pad_out) == '0) && ((is_od & pad_oe & ~drv_en) == '0));

  p_feedback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grp_in == pad_in);

  p_cfg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_flat));
endmodule

bind ioc_bank ioc_bank_chk #(.NCELL(NCELL)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_we        (cfg_we),
  .cfg_idx       (cfg_idx),
  .cfg_word      (cfg_word),
  .cfg_flat      (cfg_flat),
  .drv_en        (drv_en),
  .is_input_only (is_input_only),
  .is_od         (is_od),
  .pad_in        (pad_in),
  .pad_out       (pad_out),
  .pad_oe        (pad_oe),
  .grp_in        (grp_in)
);

// File: tb/sim_ioc_bank.sv
`timescale 1ns/1ps
module sim_ioc_bank;
  localparam int N  = 8;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic [5:0]    cfg_word = '0;
  logic          goe0 = 1'b0, goe1 = 1'b0;
  logic [N-1:0]  cell_dout = '0, cell_pt_oe = '0, pad_in = '0;
  logic [N-1:0]  pad_out, pad_oe, pad_slow, grp_in;

  always #2.5 clk = ~clk;

  ioc_bank #(.NCELL(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_word(cfg_word), .goe0(goe0), .goe1(goe1), .cell_dout(cell_dout),
    .cell_pt_oe(cell_pt_oe), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .pad_slow(pad_slow), .grp_in(grp_in)
  );

  typedef struct {
    string        tag;
    logic [N-1:0] oe;
    logic [N-1:0] lvl;
    logic [N-1:0] grp;
    logic [N-1:0] slow;
  } item_t;

  item_t      sb[$];
  logic [5:0] shadow [N];
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  // independent model: the enable is a lookup into a 4-entry vector
  task automatic expect_now(input string tag);
    item_t it;
    it.tag = tag;
    for (int i = 0; i < N; i++) begin
      logic [3:0] srcv;
      logic en;
      srcv = {cell_pt_oe[i], goe1, goe0, 1'b1};
      en = (shadow[i][1:0] == 2'd1) || ((shadow[i][1:0] == 2'd2) && srcv[shadow[i][4:3]]);
      if (shadow[i][2]) begin
        it.oe[i]  = en && !cell_dout[i];
        it.lvl[i] = 1'b0;
      end else begin
        it.oe[i]  = en;
        it.lvl[i] = cell_dout[i];
      end
      it.slow[i] = shadow[i][5];
    end
    it.grp = pad_in;
    sb.push_back(it);
  endtask

  task automatic drive(input string tag, input logic g0, input logic g1,
                       input logic [N-1:0] d, input logic [N-1:0] pt, input logic [N-1:0] pin);
    @(negedge clk);
    goe0 = g0; goe1 = g1; cell_dout = d; cell_pt_oe = pt; pad_in = pin;
    expect_now(tag);
  endtask

  task automatic write_cfg(input int idx, input logic [5:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_word = w;
    @(negedge clk);
    cfg_we = 1'b0;
    shadow[idx] = w;
  endtask

  task automatic cmp(input string tag, input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // monitor: pops each expected item once the outputs have settled
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        cmp(it.tag, "pad_oe", pad_oe, it.oe);
        cmp(it.tag, "pad_out", pad_out, it.lvl);
        cmp({it.tag, "/R8"}, "grp_in", grp_in, it.grp);
        cmp({it.tag, "/R9"}, "pad_slow", pad_slow, it.slow);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 and R3: erased cells never drive, even with every enable high
    drive("R1", 1'b1, 1'b1, 8'hA5, 8'hFF, 8'h3C);
    drive("R3", 1'b1, 1'b0, 8'h00, 8'hFF, 8'hC3);

    // R2: program eight distinct words; layout {slow, src[1:0], od, mode[1:0]}
    write_cfg(0, 6'b0_00_0_01); // output, totem              R4
    write_cfg(1, 6'b0_11_1_01); // output, open-drain, src pt R4
    write_cfg(2, 6'b0_00_0_10); // bidir, always on            R5
    write_cfg(3, 6'b0_01_0_10); // bidir, goe0                 R5
    write_cfg(4, 6'b1_10_0_10); // bidir, goe1, slow           R5
    write_cfg(5, 6'b0_11_0_10); // bidir, pt                   R5
    write_cfg(6, 6'b1_11_1_10); // bidir, pt, open-drain       R7
    write_cfg(7, 6'b1_11_0_11); // mode 3: input-only          R3
    drive("R2", 1'b0, 1'b0, 8'hFF, 8'h00, 8'h0F);

    for (int g = 0; g < 4; g++) begin
      drive("R5", g[0], g[1], 8'hFF, 8'hAA, 8'h55);
      drive("R6", g[0], g[1], 8'h55, 8'h55, 8'hAA);
      drive("R7", g[0], g[1], 8'hAA, 8'hFF, 8'hF0);
      drive("R4", g[0], g[1], 8'h00, 8'h00, 8'h00);
    end

    // R10: index and word toggle with the strobe low
    @(negedge clk);
    cfg_idx = 3'd2; cfg_word = 6'b1_01_1_00;
    @(negedge clk);
    cfg_idx = 3'd7; cfg_word = 6'b0_00_0_01;
    drive("R10", 1'b1, 1'b1, 8'h0F, 8'hFF, 8'h99);

    // R2: rewrite one cell to input-only; the neighbours keep their words
    write_cfg(2, 6'b0_00_0_00);
    drive("R2", 1'b1, 1'b1, 8'hFF, 8'hFF, 8'h66);

    // R1: reset in the middle of the run erases every word
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < N; i++) shadow[i] = '0;
    @(negedge clk);
    rst_n = 1'b1;
    drive("R1", 1'b1, 1'b1, 8'hFF, 8'hFF, 8'h81);

    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule